// File: doc/BRIEF.md
# Multichannel DDR Sample Serializer with Frame

This block takes one 12-bit conversion result per channel per sample period and sends each result on its own one-bit lane, least-significant bit first. All lanes share one forwarded bit clock and one frame signal. The forwarded clock toggles once per bit, so data moves at double data rate: twelve bits ride on six forwarded clock periods. Each forwarded clock edge falls in the middle of its bit. The frame signal rises together with bit D0 of every word. It stays high for the first half of the word and low for the second half, so a receiver can find word boundaries from the frame edge alone.

The core clock `clk` runs at twice the bit rate, which is 24 times the sample rate. Each bit is held for two core cycles, and the forwarded clock moves halfway through the bit. The parallel inputs are captured at the core edge that starts bit D0. At that edge the block can apply three changes to the word. It can invert the MSB to turn two's-complement input into offset binary. It can replace the sample on every lane with a fixed test word. While power-down is high it holds all outputs low. The channel count is a parameter.

Top module: `ddr_lane_serializer`

## Requirements
- R1: Each lane carries its channel's 12-bit word least-significant bit first, one bit after another, with a new word every 12 bits.
- R2: Each bit is held on its lane for exactly two `clk` cycles, and lanes change only on the edge that starts a bit.
- R3: `fclk_o` changes only on the edge in the middle of a bit. It is 1 from the middle of each even bit (D0, D2, …) to the middle of the following odd bit, which gives six periods per word.
- R4: `frame_o` rises on the same edge that puts D0 on the lanes. It is high during bits D0–D5 and low during bits D6–D11.
- R5: `samp_data`, `fmt_bin` and `test_en` are sampled on the edge that starts D0. Channel c takes bits [12c+11:12c] of `samp_data`.
- R6: With `fmt_bin` = 1, bit 11 of the input word is inverted (two's complement to offset binary). With `fmt_bin` = 0, the word is sent unchanged.
- R7: With `test_en` = 1, every lane sends 0x0BD (binary 0000_1011_1101), LSB first, whatever the values of `samp_data` and `fmt_bin`.
- R8: From the first `clk` edge at which `pwr_down` is high, all lanes, `fclk_o` and `frame_o` are 0. After `pwr_down` falls, the first D0 and frame rise appear on the second edge, just as after reset.
- R9: During reset all outputs are 0. After `rst` falls, `frame_o` rises on the second `clk` edge and D0 of the sampled word appears on the lanes at that edge.
- R10: Lanes are independent: each channel's recovered word depends only on its own input bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, twice the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| pwr_down | input | 1 | Holds all outputs low while high |
| fmt_bin | input | 1 | 1 selects offset binary, 0 selects two's complement |
| test_en | input | 1 | Replaces every sample with the fixed test word |
| samp_data | input | NCH*12 | Parallel two's-complement samples, channel c at [12c+11:12c] |
| lane_o | output | NCH | Serial data, one bit per channel |
| fclk_o | output | 1 | Forwarded bit clock shared by all lanes |
| frame_o | output | 1 | Word-alignment signal, rises with D0 |

## Verification
The bench uses the frame edge to recover each lane's words and compares them with words it computes itself. It uses several input sets, each aimed at a different fault. A different value on every channel shows lanes that are swapped or coupled. Alternating 0xAAA/0x555 words and a lone 0x001 show a reversed bit order or a bit slip of one position. The values 0x800 and 0x7FF, sent in both formats, show whether the MSB flip is applied, and whether it is applied to the right bit. Test mode is run with random-looking data and the binary format on, which shows any leak of sample or format into the fixed word. The forwarded clock and frame levels are checked in both halves of every bit, and a power-down in the middle of a stream checks that the outputs go quiet and that the restart timing is right.

// File: rtl/ddrser_pkg.sv
package ddrser_pkg;

    localparam int WORD_W = 12;
    localparam int HALF_W = WORD_W / 2;
    localparam int POS_W  = $clog2(WORD_W);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [POS_W-1:0]  pos_t;

    localparam word_t TEST_WORD = 12'h0BD;
    localparam pos_t  POS_LAST  = pos_t'(WORD_W - 1);
    localparam pos_t  POS_HALF  = pos_t'(HALF_W - 1);

    typedef enum logic {
        FMT_TWOS   = 1'b0,
        FMT_OFFSET = 1'b1
    } fmt_e;

    // Per-edge command from the bit sequencer to every lane
    typedef struct packed {
        logic load;
        logic shift;
    } lane_ctl_t;

    function automatic word_t encode_word(word_t raw, fmt_e fmt, logic tst);
        word_t w;
        w = raw;
        if (fmt == FMT_OFFSET)
            w[WORD_W-1] = ~raw[WORD_W-1];
        if (tst)
            w = TEST_WORD;
        return w;
    endfunction

endpackage

// File: rtl/ddrser_timing.sv
module ddrser_timing
    import ddrser_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      pd,
    output lane_ctl_t ctl,
    output logic      ph_o,
    output pos_t      pos_o,
    output logic      frame_o,
    output logic      fclk_o
);

    logic ph_q;
    pos_t pos_q;
    logic frame_q;
    logic fclk_q;

    // ph_q = 0: first half of a bit, 1: second half (forwarded edge already placed)
    always_ff @(posedge clk) begin
        if (rst || pd) begin
            ph_q    <= 1'b0;
            pos_q   <= POS_LAST;
            frame_q <= 1'b0;
            fclk_q  <= 1'b0;
        end else begin
            ph_q <= ~ph_q;
            if (!ph_q) begin
                // mid-bit edge: high after even bits, low after odd bits
                fclk_q <= ~pos_q[0];
            end else if (pos_q == POS_LAST) begin
                pos_q   <= '0;
                frame_q <= 1'b1;
            end else begin
                pos_q <= pos_q + pos_t'(1);
                if (pos_q == POS_HALF)
                    frame_q <= 1'b0;
            end
        end
    end

    always_comb begin
        ctl.load  = ph_q && (pos_q == POS_LAST);
        ctl.shift = ph_q && (pos_q != POS_LAST);
    end

    assign ph_o    = ph_q;
    assign pos_o   = pos_q;
    assign frame_o = frame_q;
    assign fclk_o  = fclk_q;

endmodule

// File: rtl/ddrser_lane.sv
module ddrser_lane
    import ddrser_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      pd,
    input  lane_ctl_t ctl,
    input  word_t     word_in,
    output logic      bit_o
);

    word_t sh_q;

    always_ff @(posedge clk) begin
        if (rst || pd)
            sh_q <= '0;
        else if (ctl.load)
            sh_q <= word_in;
        else if (ctl.shift)
            sh_q <= {1'b0, sh_q[WORD_W-1:1]};
    end

    assign bit_o = sh_q[0];

endmodule

// File: rtl/ddr_lane_serializer.sv
module ddr_lane_serializer
    import ddrser_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                pwr_down,
    input  logic                fmt_bin,
    input  logic                test_en,
    input  logic [NCH*12-1:0]   samp_data,
    output logic [NCH-1:0]      lane_o,
    output logic                fclk_o,
    output logic                frame_o
);

    lane_ctl_t ctl_w;
    logic      ph_w;
    pos_t      pos_w;
    fmt_e      fmt_w;

    assign fmt_w = fmt_e'(fmt_bin);

    ddrser_timing timing_i (
        .clk     (clk),
        .rst     (rst),
        .pd      (pwr_down),
        .ctl     (ctl_w),
        .ph_o    (ph_w),
        .pos_o   (pos_w),
        .frame_o (frame_o),
        .fclk_o  (fclk_o)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_lane
        word_t enc_w;
        assign enc_w = encode_word(samp_data[c*WORD_W +: WORD_W], fmt_w, test_en);

        ddrser_lane lane_i (
            .clk     (clk),
            .rst     (rst),
            .pd      (pwr_down),
            .ctl     (ctl_w),
            .word_in (enc_w),
            .bit_o   (lane_o[c])
        );
    end

endmodule

// File: rtl/ddrser_chk.sv
module ddrser_chk
    import ddrser_pkg::*;
#(
    parameter int NCH = 8
) (
    input logic           clk,
    input logic           rst,
    input logic           pd,
    input logic           ph,
    input pos_t           pos,
    input logic           load,
    input logic [NCH-1:0] lanes,
    input logic           fclk,
    input logic           frame
);

    // R1
    pos_range_chk: assert property (@(posedge clk) disable iff (rst)
        pos <= POS_LAST);

    // R4
    frame_rise_chk: assert property (@(posedge clk) disable iff (rst || pd)
        $rose(frame) |-> $past(load));

    // R2
    lane_hold_chk: assert property (@(posedge clk) disable iff (rst || pd)
        !ph |=> $stable(lanes));

    // R3
    fclk_mid_chk: assert property (@(posedge clk) disable iff (rst || pd)
        !$stable(fclk) |-> ph);

    // R8
    pd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        pd |=> (lanes == '0 && !fclk && !frame));

endmodule

bind ddr_lane_serializer ddrser_chk #(.NCH(NCH)) chk_i (
    .clk   (clk),
    .rst   (rst),
    .pd    (pwr_down),
    .ph    (ph_w),
    .pos   (pos_w),
    .load  (ctl_w.load),
    .lanes (lane_o),
    .fclk  (fclk_o),
    .frame (frame_o)
);

// File: tb/ddr_lane_serializer_tb_top.sv
module ddr_lane_serializer_tb_top;

    localparam int NCH = 8;
    localparam int W   = 12;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             pwr_down = 1'b0;
    logic             fmt_bin = 1'b0;
    logic             test_en = 1'b0;
    logic [NCH*W-1:0] samp_data = '0;
    logic [NCH-1:0]   lane_o;
    logic             fclk_o;
    logic             frame_o;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    ddr_lane_serializer #(.NCH(NCH)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .pwr_down  (pwr_down),
        .fmt_bin   (fmt_bin),
        .test_en   (test_en),
        .samp_data (samp_data),
        .lane_o    (lane_o),
        .fclk_o    (fclk_o),
        .frame_o   (frame_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] model(input logic [W-1:0] raw, input bit bin,
                                           input bit tst);
        logic [W-1:0] w;
        w = raw;
        if (bin) w[W-1] = ~w[W-1];
        if (tst) w = 12'h0BD;
        return w;
    endfunction

    // Sets inputs at a falling edge, waits for the frame rise, recovers one word per lane
    task automatic send_word(input logic [NCH*W-1:0] d, input bit bin, input bit tst,
                             input string req);
        logic [W-1:0] rec [NCH];
        logic [NCH-1:0] first_half;
        bit prev;
        bit hold_ok = 1'b1;
        bit fclk_ok = 1'b1;
        bit frame_ok = 1'b1;
        samp_data = d;
        fmt_bin   = bin;
        test_en   = tst;
        prev = frame_o;
        forever begin
            @(negedge clk);
            if (!prev && frame_o) break;
            prev = frame_o;
        end
        for (int k = 0; k < W; k++) begin
            first_half = lane_o;
            if (fclk_o != (k % 2 == 1)) fclk_ok = 1'b0;
            if (frame_o != (k < W/2)) frame_ok = 1'b0;
            for (int c = 0; c < NCH; c++) rec[c][k] = lane_o[c];
            @(negedge clk);
            if (lane_o != first_half) hold_ok = 1'b0;
            if (fclk_o != (k % 2 == 0)) fclk_ok = 1'b0;
            if (frame_o != (k < W/2)) frame_ok = 1'b0;
            if (k < W-1) @(negedge clk);
        end
        chk(hold_ok,  "R2 bit held two cycles", 32'(hold_ok), 1);
        chk(fclk_ok,  "R3 forwarded clock mid-bit", 32'(fclk_ok), 1);
        chk(frame_ok, "R4 frame high D0-D5", 32'(frame_ok), 1);
        for (int c = 0; c < NCH; c++) begin
            logic [W-1:0] e;
            e = model(d[c*W +: W], bin, tst);
            chk(rec[c] == e, req, 32'(rec[c]), 32'(e));
        end
    endtask

    task automatic test_reset();
        rst = 1'b1;
        samp_data = {NCH{12'h001}};
        repeat (3) @(negedge clk);
        chk(lane_o == '0 && !fclk_o && !frame_o, "R9 reset outputs",
            {lane_o, fclk_o, frame_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!frame_o, "R9 no frame after first edge", 32'(frame_o), 0);
        @(negedge clk);
        chk(frame_o, "R9 frame on second edge", 32'(frame_o), 1);
        chk(lane_o == '1, "R9 D0 on second edge", 32'(lane_o), 32'({NCH{1'b1}}));
    endtask

    task automatic test_channels();
        logic [NCH*W-1:0] d;
        for (int c = 0; c < NCH; c++) d[c*W +: W] = 12'(c * 12'h111 + 12'h0A3);
        send_word(d, 1'b0, 1'b0, "R10 R5 distinct channels");
    endtask

    task automatic test_order();
        logic [NCH*W-1:0] d;
        for (int c = 0; c < NCH; c++) d[c*W +: W] = (c % 2 == 0) ? 12'hAAA : 12'h555;
        send_word(d, 1'b0, 1'b0, "R1 alternating bits");
        send_word({NCH{12'h001}}, 1'b0, 1'b0, "R1 lone LSB");
        send_word({NCH{12'hFFF}}, 1'b0, 1'b0, "R1 all ones");
    endtask

    task automatic test_format();
        logic [NCH*W-1:0] d;
        for (int c = 0; c < NCH; c++) d[c*W +: W] = (c % 2 == 0) ? 12'h800 : 12'h7FF;
        send_word(d, 1'b1, 1'b0, "R6 offset binary");
        send_word(d, 1'b0, 1'b0, "R6 twos complement");
    endtask

    task automatic test_pattern();
        logic [NCH*W-1:0] d;
        for (int c = 0; c < NCH; c++) d[c*W +: W] = 12'(c * 12'h3C7 + 12'h915);
        send_word(d, 1'b1, 1'b1, "R7 test word");
        send_word(d, 1'b0, 1'b0, "R7 back to samples");
    endtask

    task automatic test_pd();
        bit quiet = 1'b1;
        samp_data = {NCH{12'hFFF}};
        fmt_bin = 1'b0;
        test_en = 1'b0;
        repeat (7) @(negedge clk);
        pwr_down = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (lane_o != '0 || fclk_o || frame_o) quiet = 1'b0;
        end
        chk(quiet, "R8 outputs low in power-down", 32'(quiet), 1);
        pwr_down = 1'b0;
        @(negedge clk);
        chk(!frame_o, "R8 no frame after first edge", 32'(frame_o), 0);
        @(negedge clk);
        chk(frame_o && lane_o == '1, "R8 restart on second edge",
            {lane_o, frame_o}, {{NCH{1'b1}}, 1'b1});
        send_word({NCH{12'h6B2}}, 1'b1, 1'b0, "R8 stream after power-down");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        test_reset();
        test_channels();
        test_order();
        test_format();
        test_pattern();
        test_pd();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule